// File: doc/BRIEF.md
# Bus wait-state and DMA request-sense controller

This block sits next to a small CPU/DMA bus and owns one 8-bit control register at I/O address 0x32. The register picks how many wait states stretch each memory or I/O bus cycle, whether each of two DMA request lines is used as a level or an edge, and it holds a two-bit transfer-mode field for DMA channel 1.

When the bus master starts a cycle, it strobes `cyc_start` and marks the cycle as memory or I/O. The block loads a down-counter with the wait count for that cycle type and holds `bus_ready` low until the counter reaches zero. The same settings apply whether the CPU or a DMA channel owns the cycle. The count is captured when the cycle starts, so a register write made during a stretched cycle only affects later cycles.

Each raw DMA request passes through a two-flop synchronizer. In level mode the qualified request follows the synchronized input. In edge mode a rising edge sets a pending flag, and that flag stays set until the channel's acknowledge pulse clears it.

Top module: `bwc_ctrl`

## Requirements
- R1: After reset the register reads 0xF0: 3 memory waits, 4 I/O waits, both channels in level mode, and channel-1 mode 00. `bus_ready` is high and both qualified requests are low.
- R2: A write with `reg_addr` = 0x32 stores all eight bits, and they read back on `reg_rdata` while that address is presented. A write to any other address changes nothing. A read at any other address returns 0.
- R3: Bits 7:6 set the memory wait count: code 00, 01, 10, 11 gives 0, 1, 2, 3 cycles with `bus_ready` low after a memory cycle start (`cyc_is_io` = 0).
- R4: Bits 5:4 set the I/O wait count: code 00, 01, 10, 11 gives 0, 2, 3, 4 cycles with `bus_ready` low after an I/O cycle start (`cyc_is_io` = 1).
- R5: The wait count is taken from the register value before the clock edge that accepts `cyc_start`. A write in that same cycle or later only affects the next bus cycle.
- R6: When bit 3 (channel 0) or bit 2 (channel 1) is 0, the channel is in level mode. Its `req_out` bit equals the raw request delayed by two clock edges, and `req_ack` has no effect on it.
- R7: When the channel's sense bit is 1 (edge mode), a rising raw request raises `req_out` three clock edges later. The output stays high after the raw request falls, until a one-cycle `req_ack` clears it on the next edge.
- R8: `ch1_mode` always shows register bits 1:0 unchanged.
- R9: A `cyc_start` that arrives while `bus_ready` is low is ignored. The counter keeps decrementing by one each cycle, and the stall length of the running cycle does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | I/O address for register read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 unless the address matches |
| cyc_start | input | 1 | One-cycle strobe marking the start of a bus cycle |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_ready | output | 1 | High when the current cycle may complete |
| req_raw | input | 2 | Raw DMA request inputs, bit 0 is channel 0 |
| req_ack | input | 2 | Per-channel acknowledge pulse |
| req_out | output | 2 | Qualified DMA requests |
| ch1_mode | output | 2 | Stored channel-1 transfer-mode field |

## Verification
The bound checker watches these every cycle:
- `bus_ready` only falls right after an accepted cycle start.
- A running wait counter always steps down by exactly one, whatever strobes arrive.
- A matching write lands in the register, and a non-matching write leaves it untouched.
- In edge mode a pending request never drops without an acknowledge.

Only the bench scenarios can show the following:
- the exact stall length for every memory and I/O code, including the nonlinear I/O map;
- the reset values;
- the synchronizer latencies in both sense modes;
- that a write made during a stretched cycle only shows up on the following cycle.

// File: rtl/bwc_pkg.sv
// Shared types and decode helpers for the bus wait-state controller.
// Assumes the control register layout is fixed at eight bits.
package bwc_pkg;

    localparam int CFG_W = 8;

    // Control register fields, most significant first.
    typedef struct packed {
        logic [1:0] mem_code;
        logic [1:0] io_code;
        logic       sense_ch0;
        logic       sense_ch1;
        logic [1:0] ch1_mode;
    } bwc_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 8'hF0;

    // Memory wait count is the code itself.
    function automatic logic [2:0] mem_waits(input logic [1:0] code);
        return {1'b0, code};
    endfunction

    // I/O wait count skips one: 0,2,3,4.
    function automatic logic [2:0] io_waits(input logic [1:0] code);
        return (code == 2'b00) ? 3'd0 : ({1'b0, code} + 3'd1);
    endfunction

endpackage

// File: rtl/bwc_cfg_reg.sv
// Control register with an address decoder.
// Writes are taken on the clock edge when reg_wr is high and the address
// matches. Reads are combinational and return zero on a mismatch.
module bwc_cfg_reg
    import bwc_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output bwc_cfg_t          cfg
);

    logic hit;
    assign hit = (addr == REG_ADDR);

    // Register storage: reset to maximum waits and level sense.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= bwc_cfg_t'(CFG_RESET);
        else if (wr && hit)
            cfg <= bwc_cfg_t'(wdata);
    end

    // Read mux: register contents only on an address match.
    always_comb begin
        rdata = hit ? CFG_W'(cfg) : '0;
    end

endmodule

// File: rtl/bwc_wait_gen.sv
// Wait-state generator.
// On an accepted cycle start it loads the count for the cycle type. It then
// holds ready low while the count is nonzero. A start during a stall is
// ignored.
module bwc_wait_gen
    import bwc_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_io,
    input  bwc_cfg_t         cfg,
    output logic             ready,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] load_val;

    // Select the wait count for this cycle type from the current settings.
    always_comb begin
        load_val = is_io ? CNT_W'(io_waits(cfg.io_code))
                         : CNT_W'(mem_waits(cfg.mem_code));
    end

    // Down-counter: load when idle, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
        else if (start)
            cnt <= load_val;
    end

    // Ready is high whenever no wait is outstanding.
    always_comb begin
        ready = (cnt == '0);
    end

endmodule

// File: rtl/bwc_req_cond.sv
// One DMA request conditioner.
// Synchronizes the raw request, then passes it on as a level, or latches its
// rising edge until acknowledged. Assumes SYNC_STAGES >= 2.
module bwc_req_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic ack,
    input  logic edge_mode,
    output logic qual
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_s;
    logic                   prev_q;
    logic                   pend_q;
    logic                   rise;

    assign sync_s = sync_q[SYNC_STAGES-1];
    assign rise   = sync_s & ~prev_q;

    // Synchronizer chain for the asynchronous request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    // Previous synchronized value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sync_s;
    end

    // Pending flag: a new edge wins over ack; cleared in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (!edge_mode)
            pend_q <= 1'b0;
        else
            pend_q <= (pend_q & ~ack) | rise;
    end

    // Output select by sense mode.
    always_comb begin
        qual = edge_mode ? pend_q : sync_s;
    end

endmodule

// File: rtl/bwc_ctrl.sv
// Top level of the bus wait-state and DMA request-sense controller.
// Ties together the control register, the wait generator and one request
// conditioner per DMA channel.
module bwc_ctrl
    import bwc_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h32,
    parameter int                CNT_W       = 3,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cyc_start,
    input  logic              cyc_is_io,
    output logic              bus_ready,
    input  logic [1:0]        req_raw,
    input  logic [1:0]        req_ack,
    output logic [1:0]        req_out,
    output logic [1:0]        ch1_mode
);

    localparam int NUM_CH = 2;

    bwc_cfg_t         cfg_q;
    logic [CNT_W-1:0] wait_cnt;
    logic [NUM_CH-1:0] sense_v;

    assign sense_v  = {cfg_q.sense_ch1, cfg_q.sense_ch0};
    assign ch1_mode = cfg_q.ch1_mode;

    bwc_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg_q)
    );

    bwc_wait_gen #(.CNT_W(CNT_W)) wait_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .is_io (cyc_is_io),
        .cfg   (cfg_q),
        .ready (bus_ready),
        .cnt   (wait_cnt)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        bwc_req_cond #(.SYNC_STAGES(SYNC_STAGES)) req_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw       (req_raw[ch]),
            .ack       (req_ack[ch]),
            .edge_mode (sense_v[ch]),
            .qual      (req_out[ch])
        );
    end

endmodule

// File: rtl/bwc_ctrl_chk.sv
// Protocol checker for bwc_ctrl, attached through bind.
// It observes the ports, the stored register and the wait counter.
module bwc_ctrl_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h32,
    parameter int                CNT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        cfg_q,
    input logic              cyc_start,
    input logic              bus_ready,
    input logic [1:0]        req_ack,
    input logic [1:0]        req_out,
    input logic [CNT_W-1:0]  wait_cnt
);

    // R3 R4
    ready_fall_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ready) |-> $past(cyc_start));

    // R9
    cnt_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cnt != '0) |=> (wait_cnt == $past(wait_cnt) - CNT_W'(1)));

    // R2
    hit_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_ADDR) |=> (cfg_q == $past(reg_wdata)));

    // R2
    miss_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != REG_ADDR) |=> $stable(cfg_q));

    // R7
    ch0_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[3] && req_out[0] && !req_ack[0]) |=> (req_out[0] || !cfg_q[3]));

    // R7
    ch1_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2] && req_out[1] && !req_ack[1]) |=> (req_out[1] || !cfg_q[2]));

endmodule

bind bwc_ctrl bwc_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .CNT_W    (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg_q     (cfg_q),
    .cyc_start (cyc_start),
    .bus_ready (bus_ready),
    .req_ack   (req_ack),
    .req_out   (req_out),
    .wait_cnt  (wait_cnt)
);

// File: tb/bwc_ctrl_tb_top.sv
// Scoreboard bench for bwc_ctrl.
// The driver pushes expected items into a queue. The monitor pops each item
// and compares it with the observed value.
module bwc_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cyc_start = 1'b0;
    logic       cyc_is_io = 1'b0;
    logic       bus_ready;
    logic [1:0] req_raw = 2'b00;
    logic [1:0] req_ack = 2'b00;
    logic [1:0] req_out;
    logic [1:0] ch1_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    exp;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    bwc_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cyc_start (cyc_start),
        .cyc_is_io (cyc_is_io),
        .bus_ready (bus_ready),
        .req_raw   (req_raw),
        .req_ack   (req_ack),
        .req_out   (req_out),
        .ch1_mode  (ch1_mode)
    );

    // Driver side: queue the expected value for the next observation.
    task automatic expect_item(input string tag, input int exp);
        exp_item_t it;
        it.tag = tag;
        it.exp = exp;
        exp_q.push_back(it);
    endtask

    // Monitor side: pop the oldest expectation and compare.
    task automatic observe(input int act);
        exp_item_t it;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty actual %0d expected none", act);
        end else begin
            it = exp_q.pop_front();
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s actual %0d expected %0d", it.tag, act, it.exp);
            end
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    // Start one bus cycle and count the cycles with ready low.
    task automatic measure(input logic io, output int n);
        @(negedge clk);
        cyc_start = 1'b1;
        cyc_is_io = io;
        @(negedge clk);
        cyc_start = 1'b0;
        n = 0;
        while (!bus_ready && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_edges(input int k);
        for (int i = 0; i < k; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int n;
        int io_map[4];
        io_map = '{0, 2, 3, 4};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(8'h32, v);
        expect_item("R1 reset value", 'hF0);        observe(v);
        expect_item("R1 ready after reset", 1);     observe(int'(bus_ready));
        expect_item("R1 requests idle", 0);         observe(int'(req_out));
        expect_item("R1 ch1 mode reset", 0);        observe(int'(ch1_mode));

        // R3: memory wait map
        for (int c = 0; c < 4; c++) begin
            reg_write(8'h32, 8'((c << 6) | 'h30));
            measure(1'b0, n);
            expect_item($sformatf("R3 mem code %0d", c), c); observe(n);
        end

        // R4: I/O wait map
        for (int c = 0; c < 4; c++) begin
            reg_write(8'h32, 8'((c << 4) | 'hC0));
            measure(1'b1, n);
            expect_item($sformatf("R4 io code %0d", c), io_map[c]); observe(n);
        end

        // R2 and R8: decode, readback and mode field
        reg_write(8'h32, 8'hA5);
        reg_read(8'h32, v);
        expect_item("R2 readback", 'hA5);           observe(v);
        expect_item("R8 ch1 mode", 1);              observe(int'(ch1_mode));
        reg_write(8'h33, 8'h00);
        reg_read(8'h32, v);
        expect_item("R2 miss write ignored", 'hA5); observe(v);
        reg_read(8'h33, v);
        expect_item("R2 miss read zero", 0);        observe(v);
        reg_write(8'h32, 8'h02);
        expect_item("R8 ch1 mode 10", 2);           observe(int'(ch1_mode));

        // R5: write in the start cycle applies only to the next cycle
        reg_write(8'h32, 8'hF0);
        @(negedge clk);
        cyc_start = 1'b1;
        cyc_is_io = 1'b0;
        reg_wr = 1'b1;
        reg_addr = 8'h32;
        reg_wdata = 8'h30;
        @(negedge clk);
        cyc_start = 1'b0;
        reg_wr = 1'b0;
        n = 0;
        while (!bus_ready && n < 20) begin
            n++;
            @(negedge clk);
        end
        expect_item("R5 stall uses old setting", 3); observe(n);
        measure(1'b0, n);
        expect_item("R5 next cycle uses new", 0);    observe(n);

        // R9: start during a stall is ignored
        reg_write(8'h32, 8'hF0);
        @(negedge clk);
        cyc_start = 1'b1;
        cyc_is_io = 1'b0;
        @(negedge clk);
        cyc_is_io = 1'b1;
        n = 0;
        while (!bus_ready && n < 20) begin
            n++;
            @(negedge clk);
            cyc_start = 1'b0;
        end
        cyc_start = 1'b0;
        expect_item("R9 stall unchanged", 3);        observe(n);

        // R6: level sense, two-edge latency, ack ignored
        reg_write(8'h32, 8'h00);
        @(negedge clk);
        req_raw[0] = 1'b1;
        wait_edges(1);
        expect_item("R6 not yet after one edge", 0); observe(int'(req_out[0]));
        wait_edges(1);
        expect_item("R6 level high after two", 1);   observe(int'(req_out[0]));
        req_ack[0] = 1'b1;
        wait_edges(1);
        req_ack[0] = 1'b0;
        expect_item("R6 ack ignored", 1);            observe(int'(req_out[0]));
        req_raw[0] = 1'b0;
        wait_edges(2);
        expect_item("R6 level low follows", 0);      observe(int'(req_out[0]));

        // R7: edge sense on channel 0
        reg_write(8'h32, 8'h08);
        @(negedge clk);
        req_raw[0] = 1'b1;
        wait_edges(2);
        expect_item("R7 ch0 not yet", 0);            observe(int'(req_out[0]));
        wait_edges(1);
        expect_item("R7 ch0 latched", 1);            observe(int'(req_out[0]));
        req_raw[0] = 1'b0;
        wait_edges(4);
        expect_item("R7 ch0 held after fall", 1);    observe(int'(req_out[0]));
        req_ack[0] = 1'b1;
        wait_edges(1);
        req_ack[0] = 1'b0;
        expect_item("R7 ch0 cleared by ack", 0);     observe(int'(req_out[0]));

        // R7: edge sense on channel 1, channel 0 back in level mode
        reg_write(8'h32, 8'h04);
        @(negedge clk);
        req_raw[1] = 1'b1;
        wait_edges(3);
        req_raw[1] = 1'b0;
        wait_edges(3);
        expect_item("R7 ch1 held", 1);               observe(int'(req_out[1]));
        req_ack[1] = 1'b1;
        wait_edges(1);
        req_ack[1] = 1'b0;
        expect_item("R7 ch1 cleared", 0);            observe(int'(req_out[1]));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule